// File: doc/BRIEF.md
# Bidirectional Thermal-Alert Pin Sequencer

This block shares each of two active-low, open-drain thermal alert pins between two jobs: signalling a local over-temperature event to the outside, and listening for the same kind of event from other devices on the wire. A shared prescaler divides the memory clock into base ticks, nominally 500 ns long. Each pin has its own interval down-counter, which steps on those ticks and cuts every sense period into two windows. In the drive window, a local hot event may pull the pin low and the receiver is gated off. In the sense window, the driver is released and a synchronised pin sample updates an external-hot flag.

Both windows follow from one comparison. While the interval count is above a sense-assert threshold, the pin is in the drive window. At or below the threshold, it is in the sense window. A power-management pause freezes the prescaler and both interval counters, and a resume lets them continue from the values they held. New configuration values take effect only when a counter reloads, so an edit never shortens the period that is running.

Top module: `thermal_pin_seq`

## Requirements
- R1: While reset is asserted, the base count and both interval counts read zero, `pin_oe` is 0, `rx_en` is all ones and `ext_hot` is 0.
- R2: On each running clock, the base count decrements by one. A running clock on which the count is zero reloads it from `cfg_base` and produces a base tick, so ticks are `cfg_base`+1 clocks apart. The first running clock after reset is a tick.
- R3: Each interval count changes only on a base tick. A tick decrements a nonzero count by one and reloads a zero count from `cfg_period`.
- R4: While a pin's interval count is greater than `cfg_thresh` (drive window), its `rx_en` is 0 and its `pin_oe` equals its `hot_evt`.
- R5: While a pin's interval count is at or below `cfg_thresh` (sense window), its `pin_oe` is 0 and its `rx_en` is 1.
- R6: A clock on which `pause_req` is high leaves all counters unchanged. They stay frozen on every later clock until a clock with `resume_req` high and `pause_req` low, and that clock counts again. If both are high, the pause wins.
- R7: A change to `cfg_base` or `cfg_period` leaves the running count sequence alone and is used only at the next reload.
- R8: `ext_hot` of a pin equals the inverse of its `pin_in`, taken through two synchroniser flops, and updates only on clocks where `rx_en` is 1. A pin level applied between edges k and k+1 shows on `ext_hot` after edge k+3 when the receiver is enabled. In the drive window `ext_hot` holds its value.
- R9: When `cfg_thresh` >= `cfg_period`, `pin_oe` stays 0 whatever `hot_evt` does.
- R10: The two pins share only the base tick and the configuration. The hot event and pin input of one pin never affect the outputs of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously upstream |
| cfg_base | input | PRE_W | Prescaler reload value (clocks per tick minus one) |
| cfg_period | input | CNT_W | Interval reload value, in ticks |
| cfg_thresh | input | CNT_W | Sense-assert threshold |
| pause_req | input | 1 | Freeze all counters |
| resume_req | input | 1 | Continue counting after a pause |
| hot_evt | input | NPIN | Local hot event per pin |
| pin_in | input | NPIN | Raw pin level per pin (low means hot) |
| pin_oe | output | NPIN | Drive pin low when 1, release when 0 |
| rx_en | output | NPIN | Receiver enabled (sense window) |
| ext_hot | output | NPIN | Synchronised external hot flag |
| base_cnt | output | PRE_W | Current prescaler count |
| ivl_cnt | output | NPIN*CNT_W | Interval counts, pin 0 in the low bits |

## Verification
The bench builds the block with PRE_W = 4 and CNT_W = 4 and keeps NPIN = 2. At those widths it can sweep every base value from 0 to 3, every period from 0 to 4 and every threshold from 0 to 5, for two full sense periods each. That covers both windows, the permanent-sense case and the all-ones reload of 15. Expected counts come from closed forms in the number of running clocks, which also carry the pause, resume and pause-wins sequences. Separate directed runs measure the receiver latency, the hold of the external flag during the drive window, and the deferred use of edited configuration.

// File: rtl/tps_pkg.sv
package tps_pkg;
  typedef enum logic {
    WIN_SENSE = 1'b0,
    WIN_DRIVE = 1'b1
  } win_e;
endpackage

// File: rtl/tps_prescaler.sv
module tps_prescaler #(
  parameter int PRE_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] cfg_base,
  output logic [PRE_W-1:0] cnt,
  output logic             tick
);
  logic [PRE_W-1:0] cnt_q, cnt_d;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (run) begin
      if (at_zero) cnt_d = cfg_base;
      else         cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (run) cnt_q <= cnt_d;
  end

  assign cnt  = cnt_q;
  assign tick = run & at_zero;
endmodule

// File: rtl/tps_interval.sv
module tps_interval
  import tps_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] cfg_period,
  input  logic [CNT_W-1:0] cfg_thresh,
  output logic [CNT_W-1:0] cnt,
  output win_e             win
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (tick) begin
      if (cnt_q == '0) cnt_d = cfg_period;
      else             cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
  assign win = (cnt_q > cfg_thresh) ? WIN_DRIVE : WIN_SENSE;
endmodule

// File: rtl/tps_rx_sync.sv
module tps_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  input  logic rx_en,
  output logic ext_hot
);
  logic [STAGES-1:0] sync_q;
  logic              hot_q, hot_d;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b1;
          else        sync_q[g] <= pin_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b1;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  assign hot_d = ~sync_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hot_q <= 1'b0;
    else if (rx_en) hot_q <= hot_d;
  end

  assign ext_hot = hot_q;
endmodule

// File: rtl/thermal_pin_seq.sv
module thermal_pin_seq
  import tps_pkg::*;
#(
  parameter int NPIN        = 2,
  parameter int PRE_W       = 10,
  parameter int CNT_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [PRE_W-1:0]      cfg_base,
  input  logic [CNT_W-1:0]      cfg_period,
  input  logic [CNT_W-1:0]      cfg_thresh,
  input  logic                  pause_req,
  input  logic                  resume_req,
  input  logic [NPIN-1:0]       hot_evt,
  input  logic [NPIN-1:0]       pin_in,
  output logic [NPIN-1:0]       pin_oe,
  output logic [NPIN-1:0]       rx_en,
  output logic [NPIN-1:0]       ext_hot,
  output logic [PRE_W-1:0]      base_cnt,
  output logic [NPIN*CNT_W-1:0] ivl_cnt
);
  logic paused_q, hold, run, pre_tick;

  assign hold = pause_req | (paused_q & ~resume_req);
  assign run  = ~hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) paused_q <= 1'b0;
    else        paused_q <= hold;
  end

  tps_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .cfg_base (cfg_base),
    .cnt      (base_cnt),
    .tick     (pre_tick)
  );

  genvar p;
  generate
    for (p = 0; p < NPIN; p++) begin : g_pin
      win_e win;
      logic rx_on;

      tps_interval #(.CNT_W(CNT_W)) u_ivl (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (pre_tick),
        .cfg_period (cfg_period),
        .cfg_thresh (cfg_thresh),
        .cnt        (ivl_cnt[p*CNT_W +: CNT_W]),
        .win        (win)
      );

      assign rx_on     = (win == WIN_SENSE);
      assign rx_en[p]  = rx_on;
      assign pin_oe[p] = ~rx_on & hot_evt[p];

      tps_rx_sync #(.STAGES(SYNC_STAGES)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_in  (pin_in[p]),
        .rx_en   (rx_on),
        .ext_hot (ext_hot[p])
      );
    end
  endgenerate
endmodule

// File: rtl/tps_checker.sv
module tps_checker #(
  parameter int NPIN  = 2,
  parameter int PRE_W = 10,
  parameter int CNT_W = 10
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  pause_req,
  input logic                  run,
  input logic                  pre_tick,
  input logic [NPIN-1:0]       hot_evt,
  input logic [NPIN-1:0]       pin_oe,
  input logic [NPIN-1:0]       rx_en,
  input logic [NPIN-1:0]       ext_hot,
  input logic [PRE_W-1:0]      base_cnt,
  input logic [NPIN*CNT_W-1:0] ivl_cnt
);
  AST_PRE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && base_cnt != '0) |=> (base_cnt == $past(base_cnt) - 1'b1)); // R2

  AST_PAUSE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    pause_req |=> ($stable(base_cnt) && $stable(ivl_cnt))); // R6

  genvar i;
  generate
    for (i = 0; i < NPIN; i++) begin : g_chk
      AST_IVL_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !pre_tick |=> $stable(ivl_cnt[i*CNT_W +: CNT_W])); // R3

      AST_OE_NEEDS_HOT: assert property (@(posedge clk) disable iff (!rst_n)
        pin_oe[i] |-> hot_evt[i]); // R4

      AST_SENSE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_en[i] |-> !pin_oe[i]); // R5

      AST_EXT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en[i] |=> $stable(ext_hot[i])); // R8
    end
  endgenerate
endmodule

bind thermal_pin_seq tps_checker #(
  .NPIN  (NPIN),
  .PRE_W (PRE_W),
  .CNT_W (CNT_W)
) u_tps_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .pause_req (pause_req),
  .run       (run),
  .pre_tick  (pre_tick),
  .hot_evt   (hot_evt),
  .pin_oe    (pin_oe),
  .rx_en     (rx_en),
  .ext_hot   (ext_hot),
  .base_cnt  (base_cnt),
  .ivl_cnt   (ivl_cnt)
);

// File: tb/thermal_pin_seq_bench.sv
`timescale 1ns/1ps
module thermal_pin_seq_bench;
  localparam int NPIN  = 2;
  localparam int PRE_W = 4;
  localparam int CNT_W = 4;

  logic                  clk = 1'b0;
  logic                  rst_n;
  logic [PRE_W-1:0]      cfg_base;
  logic [CNT_W-1:0]      cfg_period, cfg_thresh;
  logic                  pause_req, resume_req;
  logic [NPIN-1:0]       hot_evt, pin_in;
  logic [NPIN-1:0]       pin_oe, rx_en, ext_hot;
  logic [PRE_W-1:0]      base_cnt;
  logic [NPIN*CNT_W-1:0] ivl_cnt;

  int checks = 0;
  int errors = 0;
  int n_run;
  int B, P, T;
  bit paused_m;
  bit done = 0;

  always #2 clk = ~clk;

  thermal_pin_seq #(.NPIN(NPIN), .PRE_W(PRE_W), .CNT_W(CNT_W), .SYNC_STAGES(2))
  u_thermal_pin_seq (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_period(cfg_period),
    .cfg_thresh(cfg_thresh), .pause_req(pause_req), .resume_req(resume_req),
    .hot_evt(hot_evt), .pin_in(pin_in), .pin_oe(pin_oe), .rx_en(rx_en),
    .ext_hot(ext_hot), .base_cnt(base_cnt), .ivl_cnt(ivl_cnt)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d (B=%0d P=%0d T=%0d n=%0d)",
               req, got, exp, B, P, T, n_run);
    end
  endtask

  function automatic int exp_base(input int n);
    if (n == 0) return 0;
    return B - ((n - 1) % (B + 1));
  endfunction

  function automatic int exp_ivl(input int n);
    int t;
    t = (n == 0) ? 0 : (n - 1) / (B + 1) + 1;
    if (t == 0) return 0;
    return P - ((t - 1) % (P + 1));
  endfunction

  task automatic set_cfg(input int b, input int p, input int t);
    B = b; P = p; T = t;
    cfg_base   = PRE_W'(b);
    cfg_period = CNT_W'(p);
    cfg_thresh = CNT_W'(t);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pause_req = 1'b0; resume_req = 1'b0;
    hot_evt = '0; pin_in = '1;
    repeat (2) @(negedge clk);
    chk("R1 base", base_cnt, 0);
    chk("R1 ivl", ivl_cnt, 0);
    chk("R1 oe", pin_oe, 0);
    chk("R1 rx_en", rx_en, 3);
    chk("R1 ext_hot", ext_hot, 0);
    rst_n = 1'b1;
    n_run = 0;
    paused_m = 1'b0;
  endtask

  task automatic step();
    bit held;
    held = pause_req | (paused_m & ~resume_req);
    @(posedge clk);
    if (!held) n_run++;
    paused_m = held;
    @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    int eb, ei;
    bit drv;
    eb = exp_base(n_run);
    ei = exp_ivl(n_run);
    drv = (ei > T);
    chk({tag, " R2 base"}, base_cnt, eb);
    for (int p = 0; p < NPIN; p++) begin
      chk({tag, " R3 ivl"}, ivl_cnt[p*CNT_W +: CNT_W], ei);
      chk({tag, " R4/R5 rx_en"}, rx_en[p], !drv);
      chk({tag, " R4/R5 R10 oe"}, pin_oe[p], drv & hot_evt[p]);
      if (T >= P) chk({tag, " R9 oe"}, pin_oe[p], 0);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    set_cfg(0, 0, 0);
    rst_n = 1'b0; pause_req = 0; resume_req = 0; hot_evt = '0; pin_in = '1;

    // sweep of small configurations (R2 R3 R4 R5 R9 R10)
    for (int b = 0; b < 4; b++)
      for (int p = 0; p < 5; p++)
        for (int t = 0; t < 6; t++) begin
          set_cfg(b, p, t);
          do_reset();
          for (int c = 0; c < (b + 1) * (p + 1) * 2 + 3; c++) begin
            hot_evt = {c[0], 1'b1};
            step();
            check_all("sweep");
          end
        end

    // all-ones widths
    set_cfg(15, 15, 7);
    do_reset();
    for (int c = 0; c < 276; c++) begin
      hot_evt = {c[1], ~c[0]};
      step();
      check_all("wide");
    end

    // pause and resume, including both at once (R6)
    set_cfg(2, 3, 1);
    do_reset();
    for (int c = 0; c < 40; c++) begin
      hot_evt = 2'b11;
      pause_req  = (c == 5) || (c == 14) || (c >= 25 && c <= 27);
      resume_req = (c == 9) || (c == 14) || (c == 18) || (c == 30);
      step();
      check_all("R6 pause");
    end
    pause_req = 0; resume_req = 0;

    // configuration captured only at reloads (R7)
    set_cfg(3, 3, 15);
    do_reset();
    step();
    chk("R7 base first", base_cnt, 3);
    chk("R7 ivl first", ivl_cnt[CNT_W-1:0], 3);
    cfg_base = 4'd7; cfg_period = 4'd9;
    for (int e = 2; e <= 29; e++) begin
      step();
      if (e == 2) chk("R7 base kept", base_cnt, 2);
      if (e == 5) begin
        chk("R7 base reload", base_cnt, 7);
        chk("R7 ivl kept", ivl_cnt[CNT_W-1:0], 2);
      end
      if (e == 13) chk("R7 ivl step", ivl_cnt[CNT_W-1:0], 1);
      if (e == 29) chk("R7 ivl reload", ivl_cnt[2*CNT_W-1:CNT_W], 9);
    end

    // receiver latency in permanent sense window (R8)
    set_cfg(0, 1, 3);
    do_reset();
    repeat (3) step();
    pin_in = 2'b10;
    step(); step();
    chk("R8 latency early", ext_hot, 0);
    step();
    chk("R8 latency", ext_hot, 1);

    // hold during drive window (R8)
    set_cfg(7, 2, 0);
    do_reset();
    repeat (3) step();
    pin_in = 2'b00;
    for (int e = 4; e <= 42; e++) begin
      step();
      if (e == 16) begin
        chk("R8 drive rx", rx_en, 0);
        chk("R8 hold in drive", ext_hot, 0);
      end
      if (e == 17) chk("R8 first sense", ext_hot, 0);
      if (e == 18) chk("R8 sensed low", ext_hot, 3);
      if (e == 25) pin_in = 2'b11;
      if (e == 30) chk("R8 held high pin", ext_hot, 3);
      if (e == 42) chk("R8 resensed", ext_hot, 0);
    end

    finish_up();
  end
endmodule